// File: doc/BRIEF.md
# Streaming Eight-Point Complex DFT

This block computes an eight-point discrete Fourier transform on a stream of complex samples. Samples come in one per clock on a valid-qualified port. A start flag marks the first sample of each group of eight. When the eighth sample has arrived, the group moves through a short pipeline. The first two stages add and subtract sample pairs. The third stage scales two intermediate terms by an approximation of 1/√2. The fourth and fifth stages combine the terms into the eight bins. The bins then leave one per clock in natural order, and an output start flag marks bin 0.

The only non-trivial constant is 1/√2. It is built as a fixed sum of five shifted copies of the operand, so the block contains no multiplier. Rotations by ±j and ±1 are done by swapping and negating the real and imaginary parts. The odd bins keep eight fraction bits until the last stage and are then floored to an integer. Outputs are four bits wider than the inputs and are not scaled, so full-scale inputs never wrap.

The collection register and the bin register are each read on the same edge that overwrites them. A new frame can therefore be collected while the previous one is still being emitted. Gap-free input frames give a gap-free output stream.

Top module: `wdft8_stream`

## Requirements
- R1: While reset is asserted and after it is released, with no frame supplied, out_valid and out_sof are 0 and out_re and out_im are 0.
- R2: A cycle with in_valid=1 and in_sof=1 takes sample 0 of a frame. The next seven cycles with in_valid=1 and in_sof=0 take samples 1 to 7. Cycles with in_valid=0 are skipped and do not advance the frame.
- R3: Samples with in_valid=1 and in_sof=0 that arrive while no frame is being collected are ignored and produce no output.
- R4: A sample with in_sof=1 that arrives part-way through a frame discards the partial frame and starts a new one. Only the new frame produces bins.
- R5: Each complete frame produces exactly eight consecutive cycles of out_valid=1, carrying bins 0 to 7 in natural order. out_sof=1 only together with bin 0.
- R6: Bin 0 is presented exactly 6 clock edges after the edge that accepts sample 7. A gap-free frame therefore spans 14 cycles from sample 0 to bin 0.
- R7: Each bin satisfies X(k) = Σ x(n)·e^(−j2πnk/8), unscaled. Real and imaginary parts each lie within 3 LSB of the exact value.
- R8: When a frame's sample 0 immediately follows the previous frame's sample 7, its bin 0 immediately follows the previous frame's bin 7, with no idle output cycle.
- R9: For inputs in the symmetric range ±(2^(DW−1)−1), including worst-case full-scale patterns, the DW+4-bit outputs never wrap and stay within the R7 tolerance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_sof | input | 1 | Marks sample 0 of a frame |
| in_re | input | DW | Input real part, signed |
| in_im | input | DW | Input imaginary part, signed |
| out_valid | output | 1 | Output bin qualifier |
| out_sof | output | 1 | Marks bin 0 of a frame |
| out_re | output | DW+4 | Bin real part, signed |
| out_im | output | DW+4 | Bin imaginary part, signed |

## Verification
The assertions assume that neither input component ever takes the most negative code. They also assume that in_sof is only acted on when in_valid is high. The random stimulus draws every component uniformly from the symmetric range ±(2^(DW−1)−1). The directed full-scale patterns stay on that range's edges. Stray samples without a start flag, truncated frames, gapped frames and back-to-back bursts are all driven with in_valid high only on intended samples, so the collection assertions see well-formed traffic.

// File: rtl/wdft8_pkg.sv
package wdft8_pkg;

  // Points per transform and fraction bits kept through the scaled path.
  localparam int unsigned NPT  = 8;
  localparam int unsigned FRAC = 8;

  typedef enum logic {
    GATHER_IDLE,
    GATHER_BUSY
  } gather_e;

  // v * 181/256 in units of 2^-FRAC: 2^-1 + 2^-3 + 2^-4 + 2^-6 + 2^-8.
  function automatic logic signed [63:0] rsqrt2_scaled(input logic signed [63:0] v);
    return (v <<< 7) + (v <<< 5) + (v <<< 4) + (v <<< 2) + v;
  endfunction

endpackage

// File: rtl/wdft8_gather.sv
module wdft8_gather
  import wdft8_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic signed [DW-1:0] smp_re [NPT],
  output logic signed [DW-1:0] smp_im [NPT],
  output logic                 go
);

  localparam int unsigned PW = $clog2(NPT);
  localparam logic signed [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

  gather_e       st;
  logic [PW-1:0] pos;

  // Named events for the assertions
  logic take_first, take_next, last_take;
  assign take_first = in_valid && in_sof;
  assign take_next  = in_valid && !in_sof && (st == GATHER_BUSY);
  assign last_take  = take_next && (pos == PW'(NPT-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= GATHER_IDLE;
      pos <= '0;
      go  <= 1'b0;
    end else begin
      go <= last_take;
      if (take_first) begin
        st  <= GATHER_BUSY;
        pos <= PW'(1);
      end else if (take_next) begin
        pos <= pos + PW'(1);
        if (last_take) st <= GATHER_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take_first) begin
      smp_re[0] <= in_re;
      smp_im[0] <= in_im;
    end else if (take_next) begin
      smp_re[pos] <= in_re;
      smp_im[pos] <= in_im;
    end
  end

  // R2
  go_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> $past(in_valid && !in_sof));

  // R4
  go_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);

  // R9
  in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (in_re != MOST_NEG && in_im != MOST_NEG));

endmodule

// File: rtl/wdft8_kernel.sv
module wdft8_kernel
  import wdft8_pkg::*;
#(
  parameter int unsigned DW = 12,
  localparam int unsigned OW = DW + 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic signed [DW-1:0] smp_re [NPT],
  input  logic signed [DW-1:0] smp_im [NPT],
  output logic signed [OW-1:0] bin_re [NPT],
  output logic signed [OW-1:0] bin_im [NPT],
  output logic                 bins_ld
);

  localparam int unsigned A1 = DW + 1;
  localparam int unsigned A2 = DW + 2;
  localparam int unsigned A3 = DW + 3;
  localparam int unsigned AW = DW + 4 + FRAC;

  function automatic logic signed [A1-1:0] pair1(input logic signed [DW-1:0] p,
                                                  input logic signed [DW-1:0] q,
                                                  input logic neg);
    return neg ? (A1'(p) - A1'(q)) : (A1'(p) + A1'(q));
  endfunction

  function automatic logic signed [A2-1:0] pair2(input logic signed [A1-1:0] p,
                                                  input logic signed [A1-1:0] q,
                                                  input logic neg);
    return neg ? (A2'(p) - A2'(q)) : (A2'(p) + A2'(q));
  endfunction

  function automatic logic signed [AW-1:0] scale_c(input logic signed [A2-1:0] v);
    return AW'(rsqrt2_scaled(64'(v)));
  endfunction

  function automatic logic signed [OW-1:0] drop_frac(input logic signed [AW-1:0] v);
    logic signed [AW-1:0] sh;
    sh = v >>> FRAC;
    return sh[OW-1:0];
  endfunction

  // Stage 1: pairs (0,4) (2,6) (1,5) (3,7); lane p takes bit-reversed base.
  logic signed [A1-1:0] a_re_d [NPT];
  logic signed [A1-1:0] a_im_d [NPT];
  logic signed [A1-1:0] a_re   [NPT];
  logic signed [A1-1:0] a_im   [NPT];

  for (genvar p = 0; p < 4; p++) begin : g_st1
    localparam int BASE = ((p & 1) << 1) | (p >> 1);
    assign a_re_d[2*p]   = pair1(smp_re[BASE], smp_re[BASE+4], 1'b0);
    assign a_im_d[2*p]   = pair1(smp_im[BASE], smp_im[BASE+4], 1'b0);
    assign a_re_d[2*p+1] = pair1(smp_re[BASE], smp_re[BASE+4], 1'b1);
    assign a_im_d[2*p+1] = pair1(smp_im[BASE], smp_im[BASE+4], 1'b1);
  end

  // Stage 2: pairs of stage-1 terms (0,2) (4,6) (5,7)
  logic signed [A2-1:0] b_re_d [6];
  logic signed [A2-1:0] b_im_d [6];
  logic signed [A2-1:0] b_re   [6];
  logic signed [A2-1:0] b_im   [6];
  logic signed [A1-1:0] p1_re, p1_im, p3_re, p3_im;

  for (genvar q = 0; q < 3; q++) begin : g_st2
    localparam int LEFT = (q == 0) ? 0 : ((q == 1) ? 4 : 5);
    assign b_re_d[2*q]   = pair2(a_re[LEFT], a_re[LEFT+2], 1'b0);
    assign b_im_d[2*q]   = pair2(a_im[LEFT], a_im[LEFT+2], 1'b0);
    assign b_re_d[2*q+1] = pair2(a_re[LEFT], a_re[LEFT+2], 1'b1);
    assign b_im_d[2*q+1] = pair2(a_im[LEFT], a_im[LEFT+2], 1'b1);
  end

  // Stage 3: constant scaling, the rest moves to fixed point
  logic signed [AW-1:0] m1_re, m1_im, m2_re, m2_im;
  logic signed [AW-1:0] h1_re, h1_im, h3_re, h3_im;
  logic signed [A2-1:0] c_re [4];
  logic signed [A2-1:0] c_im [4];

  // Stage 4: post additions
  logic signed [AW-1:0] s1_re, s1_im, s2_re, s2_im;
  logic signed [AW-1:0] t1_re, t1_im, t2_re, t2_im;
  logic signed [A3-1:0] e0_re, e0_im, e4_re, e4_im;
  logic signed [A2-1:0] d1_re, d1_im, d3_re, d3_im;

  logic v1, v2, v3, v4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1      <= 1'b0;
      v2      <= 1'b0;
      v3      <= 1'b0;
      v4      <= 1'b0;
      bins_ld <= 1'b0;
    end else begin
      v1      <= go;
      v2      <= v1;
      v3      <= v2;
      v4      <= v3;
      bins_ld <= v4;
    end
  end

  always_ff @(posedge clk) begin
    if (go) begin
      for (int i = 0; i < NPT; i++) begin
        a_re[i] <= a_re_d[i];
        a_im[i] <= a_im_d[i];
      end
    end
    if (v1) begin
      for (int i = 0; i < 6; i++) begin
        b_re[i] <= b_re_d[i];
        b_im[i] <= b_im_d[i];
      end
      p1_re <= a_re[1];
      p1_im <= a_im[1];
      p3_re <= a_re[3];
      p3_im <= a_im[3];
    end
    if (v2) begin
      m1_re <= scale_c(b_re[5]);
      m1_im <= scale_c(b_im[5]);
      m2_re <= scale_c(b_re[4]);
      m2_im <= scale_c(b_im[4]);
      h1_re <= AW'(p1_re) <<< FRAC;
      h1_im <= AW'(p1_im) <<< FRAC;
      h3_re <= AW'(p3_re) <<< FRAC;
      h3_im <= AW'(p3_im) <<< FRAC;
      for (int i = 0; i < 4; i++) begin
        c_re[i] <= b_re[i];
        c_im[i] <= b_im[i];
      end
    end
    if (v3) begin
      s1_re <= h1_re + m1_re;
      s1_im <= h1_im + m1_im;
      s2_re <= h1_re - m1_re;
      s2_im <= h1_im - m1_im;
      t1_re <= h3_re + m2_re;
      t1_im <= h3_im + m2_im;
      t2_re <= h3_re - m2_re;
      t2_im <= h3_im - m2_im;
      e0_re <= A3'(c_re[0]) + A3'(c_re[2]);
      e0_im <= A3'(c_im[0]) + A3'(c_im[2]);
      e4_re <= A3'(c_re[0]) - A3'(c_re[2]);
      e4_im <= A3'(c_im[0]) - A3'(c_im[2]);
      d1_re <= c_re[1];
      d1_im <= c_im[1];
      d3_re <= c_re[3];
      d3_im <= c_im[3];
    end
    if (v4) begin
      bin_re[0] <= OW'(e0_re);
      bin_im[0] <= OW'(e0_im);
      bin_re[4] <= OW'(e4_re);
      bin_im[4] <= OW'(e4_im);
      // rotations by -j and +j are swaps with a negation
      bin_re[2] <= OW'(d1_re) + OW'(d3_im);
      bin_im[2] <= OW'(d1_im) - OW'(d3_re);
      bin_re[6] <= OW'(d1_re) - OW'(d3_im);
      bin_im[6] <= OW'(d1_im) + OW'(d3_re);
      bin_re[1] <= drop_frac(s1_re + t1_im);
      bin_im[1] <= drop_frac(s1_im - t1_re);
      bin_re[7] <= drop_frac(s1_re - t1_im);
      bin_im[7] <= drop_frac(s1_im + t1_re);
      bin_re[3] <= drop_frac(s2_re - t2_im);
      bin_im[3] <= drop_frac(s2_im + t2_re);
      bin_re[5] <= drop_frac(s2_re + t2_im);
      bin_im[5] <= drop_frac(s2_im - t2_re);
    end
  end

  // R6
  kernel_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bins_ld |-> $past(go, 5));

  // R8
  kernel_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bins_ld |=> !bins_ld);

endmodule

// File: rtl/wdft8_emit.sv
module wdft8_emit
  import wdft8_pkg::*;
#(
  parameter int unsigned OW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bins_ld,
  input  logic signed [OW-1:0] bin_re [NPT],
  input  logic signed [OW-1:0] bin_im [NPT],
  output logic                 out_valid,
  output logic                 out_sof,
  output logic signed [OW-1:0] out_re,
  output logic signed [OW-1:0] out_im
);

  localparam int unsigned IW = $clog2(NPT);

  logic [IW-1:0] idx;
  logic          run;
  logic          last_bin;
  assign last_bin = run && (idx == IW'(NPT-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      run       <= 1'b0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else if (bins_ld) begin
      out_re    <= bin_re[0];
      out_im    <= bin_im[0];
      out_valid <= 1'b1;
      out_sof   <= 1'b1;
      idx       <= IW'(1);
      run       <= 1'b1;
    end else if (run) begin
      out_re    <= bin_re[idx];
      out_im    <= bin_im[idx];
      out_valid <= 1'b1;
      out_sof   <= 1'b0;
      idx       <= idx + IW'(1);
      if (last_bin) run <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
    end
  end

  // Checker state: bins presented since the last bin 0
  logic [IW:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   seen <= '0;
    else if (out_valid && out_sof) seen <= (IW+1)'(1);
    else if (out_valid)            seen <= seen + (IW+1)'(1);
  end

  // R5
  sof_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sof);

  // R5
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sof) |-> (seen >= (IW+1)'(1) && seen <= (IW+1)'(NPT-1)));

  // R5
  run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> (seen == (IW+1)'(NPT)));

  // R8
  sof_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof && $past(out_valid)) |-> ($past(seen) == (IW+1)'(NPT-1)));

endmodule

// File: rtl/wdft8_stream.sv
module wdft8_stream
  import wdft8_pkg::*;
#(
  parameter int unsigned DW = 12,
  localparam int unsigned OW = DW + 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  output logic                 out_sof,
  output logic signed [OW-1:0] out_re,
  output logic signed [OW-1:0] out_im
);

  logic signed [DW-1:0] smp_re [NPT];
  logic signed [DW-1:0] smp_im [NPT];
  logic signed [OW-1:0] bin_re [NPT];
  logic signed [OW-1:0] bin_im [NPT];
  logic                 go;
  logic                 bins_ld;

  wdft8_gather #(.DW(DW)) u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .in_re    (in_re),
    .in_im    (in_im),
    .smp_re   (smp_re),
    .smp_im   (smp_im),
    .go       (go)
  );

  wdft8_kernel #(.DW(DW)) u_kernel (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .smp_re  (smp_re),
    .smp_im  (smp_im),
    .bin_re  (bin_re),
    .bin_im  (bin_im),
    .bins_ld (bins_ld)
  );

  wdft8_emit #(.OW(OW)) u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .bins_ld   (bins_ld),
    .bin_re    (bin_re),
    .bin_im    (bin_im),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_re    (out_re),
    .out_im    (out_im)
  );

endmodule

// File: tb/sim_wdft8_stream.sv
module sim_wdft8_stream;

  localparam int DW   = 12;
  localparam int OW   = DW + 4;
  localparam int MAXV = (1 << (DW - 1)) - 1;
  localparam real TOL = 3.0;
  localparam real PI  = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic                 in_valid = 1'b0;
  logic                 in_sof = 1'b0;
  logic signed [DW-1:0] in_re = '0;
  logic signed [DW-1:0] in_im = '0;
  logic                 out_valid, out_sof;
  logic signed [OW-1:0] out_re, out_im;

  wdft8_stream #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_sof(out_sof),
    .out_re(out_re), .out_im(out_im)
  );

  int n_chk = 0;
  int n_fail = 0;
  int unsigned cyc = 0;
  int out_cnt = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  real         exp_re_q [$];
  real         exp_im_q [$];
  int unsigned lat_q [$];
  bit          b2b_q [$];
  string       tag_q [$];
  int frm_re [8];
  int frm_im [8];

  task automatic check(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic real rabs(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic put(input bit v, input bit s, input int re, input int im);
    @(negedge clk);
    in_valid = v;
    in_sof   = s;
    in_re    = DW'(re);
    in_im    = DW'(im);
  endtask

  task automatic idle(input int n);
    repeat (n) put(1'b0, 1'b0, 0, 0);
  endtask

  task automatic fill_random();
    for (int k = 0; k < 8; k++) begin
      frm_re[k] = int'($urandom_range(2 * MAXV)) - MAXV;
      frm_im[k] = int'($urandom_range(2 * MAXV)) - MAXV;
    end
  endtask

  // Exact DFT in floating point, then the frame is driven.
  task automatic send_frame(input int gap, input bit b2b, input string tag);
    for (int k = 0; k < 8; k++) begin
      real sr = 0.0;
      real si = 0.0;
      for (int n = 0; n < 8; n++) begin
        real th = 2.0 * PI * real'(n * k) / 8.0;
        sr += real'(frm_re[n]) * $cos(th) + real'(frm_im[n]) * $sin(th);
        si += real'(frm_im[n]) * $cos(th) - real'(frm_re[n]) * $sin(th);
      end
      exp_re_q.push_back(sr);
      exp_im_q.push_back(si);
    end
    b2b_q.push_back(b2b);
    tag_q.push_back(tag);
    for (int k = 0; k < 8; k++) begin
      if (k > 0 && gap > 0) idle(gap);
      put(1'b1, k == 0, frm_re[k], frm_im[k]);
    end
    lat_q.push_back(cyc + 1);  // edge that takes sample 7
  endtask

  // Output monitor, away from the active edge
  int    bin_idx = 0;
  bit    prev_v = 1'b0;
  string cur_tag = "R7";
  real   er, ei;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        out_cnt++;
        if (exp_re_q.size() == 0) begin
          check(1'b0, $sformatf("R3 unexpected bin: got re=%0d im=%0d, expected no output",
                                out_re, out_im));
        end else begin
          er = exp_re_q.pop_front();
          ei = exp_im_q.pop_front();
          if (bin_idx == 0) begin
            int unsigned acc;
            bit want_b2b;
            acc = lat_q.pop_front();
            want_b2b = b2b_q.pop_front();
            cur_tag = tag_q.pop_front();
            check(cyc - acc == 6, $sformatf("R6 latency: got %0d edges, expected 6", cyc - acc));
            if (want_b2b)
              check(prev_v, $sformatf("R8 gap before bin 0: got prev valid=%0d, expected 1", prev_v));
          end
          check(out_sof == (bin_idx == 0),
                $sformatf("R5 bin %0d: got sof=%0d, expected %0d", bin_idx, out_sof, bin_idx == 0));
          check(rabs(real'(int'(out_re)) - er) <= TOL && rabs(real'(int'(out_im)) - ei) <= TOL,
                $sformatf("%s bin %0d: got (%0d,%0d), expected (%0.2f,%0.2f)",
                          cur_tag, bin_idx, out_re, out_im, er, ei));
          bin_idx = (bin_idx + 1) % 8;
        end
      end
      prev_v = out_valid;
    end
  end

  initial begin
    void'($urandom(32'd734));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check(!out_valid && !out_sof && out_re == 0 && out_im == 0,
          $sformatf("R1 in reset: got v=%0d s=%0d re=%0d im=%0d, expected all 0",
                    out_valid, out_sof, out_re, out_im));
    rst_n = 1'b1;
    idle(4);
    check(!out_valid && !out_sof && out_re == 0 && out_im == 0,
          $sformatf("R1 after reset: got v=%0d s=%0d re=%0d im=%0d, expected all 0",
                    out_valid, out_sof, out_re, out_im));

    // R3: stray samples without a start flag
    repeat (6) put(1'b1, 1'b0, 300, -200);
    idle(20);
    check(out_cnt == 0, $sformatf("R3 stray samples: got %0d bins, expected 0", out_cnt));

    // R7: impulse at sample 0 gives a flat spectrum
    for (int k = 0; k < 8; k++) begin frm_re[k] = 0; frm_im[k] = 0; end
    frm_re[0] = MAXV;
    send_frame(0, 1'b0, "R7 impulse");
    idle(16);

    // R9: constant full scale
    for (int k = 0; k < 8; k++) begin frm_re[k] = MAXV; frm_im[k] = -MAXV; end
    send_frame(0, 1'b0, "R9 const");
    idle(16);

    // R9: worst case for bin 1 real part
    frm_re = '{MAXV, MAXV, 0, -MAXV, -MAXV, -MAXV, 0, MAXV};
    frm_im = '{0, MAXV, MAXV, MAXV, 0, -MAXV, -MAXV, -MAXV};
    send_frame(0, 1'b0, "R9 peak");
    idle(16);

    // R9: negated worst case
    for (int k = 0; k < 8; k++) begin frm_re[k] = -frm_re[k]; frm_im[k] = -frm_im[k]; end
    send_frame(0, 1'b0, "R9 peak neg");
    idle(16);

    // R4: partial frame then restart
    put(1'b1, 1'b1, 900, 900);
    put(1'b1, 1'b0, -900, 400);
    put(1'b1, 1'b0, 123, -77);
    fill_random();
    send_frame(0, 1'b0, "R4 restart");
    idle(16);

    // R2: gapped input frames
    fill_random();
    send_frame(1, 1'b0, "R2 gap1");
    idle(16);
    fill_random();
    send_frame(3, 1'b0, "R2 gap3");
    idle(16);

    // R8: back-to-back burst
    for (int f = 0; f < 10; f++) begin
      fill_random();
      send_frame(0, f != 0, "R8 burst");
    end
    idle(16);

    // R7: random frames, random gaps and spacing
    for (int f = 0; f < 40; f++) begin
      fill_random();
      send_frame(int'($urandom_range(1)), 1'b0, "R7 random");
      if ($urandom_range(1) == 1) idle(int'($urandom_range(12)));
    end
    idle(30);

    // R5: every frame fully emitted
    check(exp_re_q.size() == 0,
          $sformatf("R5 pending bins: got %0d left, expected 0", exp_re_q.size()));
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R5 watchdog: got run still active, expected completion");
      done = 1'b1;
      report();
      $finish;
    end
  end

endmodule